// File: doc/BRIEF.md
# Load Ordering Wait Predictor

The block holds a small table of one-bit entries. Each entry says whether a load at a given program counter should be held back until all older stores have issued. A load PC reaches its entry through a hashed index: slices of the PC are folded together with XOR. Several loads can be looked up at once through independent lookup ports. Each lookup returns a wait bit combinationally from the registered table.

Whenever the memory pipeline reports that a load was replayed for a memory-ordering violation, the load's PC is presented on an update port and its entry is marked. The table takes at most one write per cycle, so colliding reports are settled by port number. An enable input, driven from a control register bit elsewhere, forces every lookup result to "no wait" while leaving the table untouched. A free-running decay counter wipes the whole table at a fixed interval, so that stale predictions age out.

Top module: `lvp_wait_predictor`

## Requirements
- R1: While rst_ni is low, all table entries are cleared at once, without waiting for a clock edge. After reset every lookup returns 0.
- R2: The index is the XOR of consecutive IDX_W-bit slices of the PC, taken from bit 0 upward. The top slice is zero-padded when PC_W is not a multiple of IDX_W. With PC_W=32 and IDX_W=6, the index is pc[5:0]^pc[11:6]^pc[17:12]^pc[23:18]^pc[29:24]^{4'b0,pc[31:30]}. PCs with equal folds share one entry.
- R3: An update on a valid port sets its entry at the next clock edge. A lookup in the same cycle as the update still sees the old value.
- R4: Only one entry is written per cycle. The lowest-numbered valid update port wins, and updates on the other ports in that cycle are dropped.
- R5: While pred_en_i is 0, every lk_wait_o bit is 0. Updates still train the table, and its contents are kept.
- R6: At every DECAY_CYCLES-th rising clock edge after reset is released, the whole table is cleared. That clear overrides any update at the same edge, and entries set before that edge still read 1 in the cycle just before it.
- R7: Each lookup port returns, in the same cycle, the entry for its own PC, independently of the other lookup ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pred_en_i | input | 1 | Prediction enable from a control register bit |
| lk_pc_i | input | N_LK*PC_W | PCs of the loads being looked up, one per lookup port |
| lk_wait_o | output | N_LK | Wait bit for each lookup port |
| upd_vld_i | input | N_UPD | Violation report valid, one per update port |
| upd_pc_i | input | N_UPD*PC_W | PC of the load that violated, one per update port |

## Verification
Lookup results are combinational, so they are due in the same cycle as the PC. An update shows up only after the next rising edge. The bench drives every input on the falling edge and samples lk_wait_o one time unit later. Each check therefore sees the table as it stood after the previous rising edge, which shows both the one-cycle update delay and the unchanged value within the update cycle. The decay clear falls on a counted edge. The bench tracks rising edges since reset release, checks the cycle just before the DECAY_CYCLES-th edge, and checks again just after it.

// File: rtl/lvp_pkg.sv
package lvp_pkg;
  function automatic int num_slices(input int pc_w, input int idx_w);
    return (pc_w + idx_w - 1) / idx_w;
  endfunction
endpackage

// File: rtl/lvp_fold.sv
module lvp_fold #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int NSL   = lvp_pkg::num_slices(PC_W, IDX_W);
  localparam int PAD_W = NSL * IDX_W;

  logic [PAD_W-1:0] pc_pad;
  logic [IDX_W-1:0] acc [NSL+1];

  assign pc_pad = PAD_W'(pc_i);
  assign acc[0] = '0;

  for (genvar s = 0; s < NSL; s++) begin : g_slice
    assign acc[s+1] = acc[s] ^ pc_pad[s*IDX_W +: IDX_W];
  end

  assign idx_o = acc[NSL];
endmodule

// File: rtl/lvp_wr_arb.sv
module lvp_wr_arb #(
  parameter int N_UPD = 2,
  parameter int IDX_W = 6
) (
  input  logic [N_UPD-1:0]            vld_i,
  input  logic [N_UPD-1:0][IDX_W-1:0] idx_i,
  output logic                        we_o,
  output logic [IDX_W-1:0]            widx_o
);
  // walk from highest port down so the lowest valid port wins
  always_comb begin
    we_o   = 1'b0;
    widx_o = '0;
    for (int p = N_UPD - 1; p >= 0; p--) begin
      if (vld_i[p]) begin
        we_o   = 1'b1;
        widx_o = idx_i[p];
      end
    end
  end
endmodule

// File: rtl/lvp_decay.sv
module lvp_decay #(
  parameter int PERIOD = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clr_o
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  assign clr_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lvp_wait_predictor.sv
module lvp_wait_predictor #(
  parameter int PC_W         = 32,
  parameter int IDX_W        = 6,
  parameter int N_LK         = 2,
  parameter int N_UPD        = 2,
  parameter int DECAY_CYCLES = 4096
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pred_en_i,
  input  logic [N_LK-1:0][PC_W-1:0]  lk_pc_i,
  output logic [N_LK-1:0]            lk_wait_o,
  input  logic [N_UPD-1:0]           upd_vld_i,
  input  logic [N_UPD-1:0][PC_W-1:0] upd_pc_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]            table_q;
  logic [N_UPD-1:0][IDX_W-1:0] upd_idx;
  logic                        we;
  logic [IDX_W-1:0]            widx;
  logic                        decay_clr;

  for (genvar u = 0; u < N_UPD; u++) begin : g_upd
    lvp_fold #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fold (
      .pc_i  (upd_pc_i[u]),
      .idx_o (upd_idx[u])
    );
  end

  lvp_wr_arb #(.N_UPD(N_UPD), .IDX_W(IDX_W)) u_arb (
    .vld_i  (upd_vld_i),
    .idx_i  (upd_idx),
    .we_o   (we),
    .widx_o (widx)
  );

  lvp_decay #(.PERIOD(DECAY_CYCLES)) u_decay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_o  (decay_clr)
  );

  // decay clear wins over a same-edge write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        table_q <= '0;
    else if (decay_clr) table_q <= '0;
    else if (we)        table_q[widx] <= 1'b1;
  end

  for (genvar l = 0; l < N_LK; l++) begin : g_lk
    logic [IDX_W-1:0] lk_idx;
    lvp_fold #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fold (
      .pc_i  (lk_pc_i[l]),
      .idx_o (lk_idx)
    );
    assign lk_wait_o[l] = pred_en_i & table_q[lk_idx];
  end
endmodule

// File: rtl/lvp_wait_predictor_chk.sv
module lvp_wait_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int N_LK  = 2,
  parameter int N_UPD = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       pred_en_i,
  input logic [N_LK-1:0][PC_W-1:0]  lk_pc_i,
  input logic [N_LK-1:0]            lk_wait_o,
  input logic [N_UPD-1:0]           upd_vld_i,
  input logic [N_UPD-1:0][PC_W-1:0] upd_pc_i,
  input logic [(1<<IDX_W)-1:0]      table_q,
  input logic                       decay_clr
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_empty: assert (table_q == '0 && lk_wait_o == '0);
    end
  end

  a_r3_update_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upd_vld_i[0]) && !$past(decay_clr) && pred_en_i &&
     lk_pc_i[0] == $past(upd_pc_i[0])) |-> lk_wait_o[0]);

  a_r4_one_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(decay_clr) |-> ($countones(table_q) <= $countones($past(table_q)) + 1));

  a_r5_disabled_no_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_en_i |-> (lk_wait_o == '0));

  a_r6_decay_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(decay_clr) |-> (lk_wait_o == '0 && table_q == '0));
endmodule

bind lvp_wait_predictor lvp_wait_predictor_chk #(
  .PC_W(PC_W), .IDX_W(IDX_W), .N_LK(N_LK), .N_UPD(N_UPD)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pred_en_i (pred_en_i),
  .lk_pc_i   (lk_pc_i),
  .lk_wait_o (lk_wait_o),
  .upd_vld_i (upd_vld_i),
  .upd_pc_i  (upd_pc_i),
  .table_q   (table_q),
  .decay_clr (decay_clr)
);

// File: tb/lvp_wait_predictor_tb.sv
module lvp_wait_predictor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DECAY      = 64;
  localparam int NV         = 13;

  typedef struct packed {
    logic [1:0]  uv;
    logic [31:0] up0;
    logic [31:0] up1;
    logic [31:0] lp0;
    logic [31:0] lp1;
    logic        en;
    logic [1:0]  exp;
  } vec_t;

  // exp[0] belongs to lookup port 0
  localparam vec_t VEC [NV] = '{
    '{2'b00, 32'h0,    32'h0,    32'h05,  32'h145,       1'b1, 2'b00},
    '{2'b01, 32'h05,   32'h0,    32'h05,  32'h140,       1'b1, 2'b00},
    '{2'b00, 32'h0,    32'h0,    32'h05,  32'h140,       1'b1, 2'b11},
    '{2'b00, 32'h0,    32'h0,    32'h145, 32'h1000,      1'b1, 2'b00},
    '{2'b11, 32'h1000, 32'h02,   32'h40,  32'h02,        1'b1, 2'b00},
    '{2'b00, 32'h0,    32'h0,    32'h40,  32'h02,        1'b1, 2'b01},
    '{2'b10, 32'h0,    32'h02,   32'h02,  32'h05,        1'b1, 2'b10},
    '{2'b00, 32'h0,    32'h0,    32'h02,  32'hC0000002,  1'b1, 2'b11},
    '{2'b00, 32'h0,    32'h0,    32'h05,  32'h40,        1'b0, 2'b00},
    '{2'b01, 32'h3F,   32'h0,    32'h3F,  32'h05,        1'b0, 2'b00},
    '{2'b00, 32'h0,    32'h0,    32'h3F,  32'h145,       1'b1, 2'b01},
    '{2'b11, 32'h07,   32'h1C0,  32'h07,  32'h1C7,       1'b1, 2'b00},
    '{2'b00, 32'h0,    32'h0,    32'h07,  32'h1C0,       1'b1, 2'b11}
  };
  localparam string TAG [NV] = '{"R1", "R3", "R2", "R2", "R4", "R4", "R7",
                                  "R2", "R5", "R5", "R5", "R3", "R4"};

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pred_en_i = 1'b0;
  logic [1:0][31:0] lk_pc_i = '0;
  logic [1:0]       lk_wait_o;
  logic [1:0]       upd_vld_i = '0;
  logic [1:0][31:0] upd_pc_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  lvp_wait_predictor #(
    .PC_W(32), .IDX_W(6), .N_LK(2), .N_UPD(2), .DECAY_CYCLES(DECAY)
  ) u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pred_en_i (pred_en_i),
    .lk_pc_i   (lk_pc_i),
    .lk_wait_o (lk_wait_o),
    .upd_vld_i (upd_vld_i),
    .upd_pc_i  (upd_pc_i)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: lk_wait_o act=%b exp=%b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [1:0] uv, input logic [31:0] up0, input logic [31:0] up1,
                       input logic [31:0] lp0, input logic [31:0] lp1, input logic en);
    upd_vld_i   = uv;
    upd_pc_i[0] = up0;
    upd_pc_i[1] = up1;
    lk_pc_i[0]  = lp0;
    lk_pc_i[1]  = lp1;
    pred_en_i   = en;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VEC[i].uv, VEC[i].up0, VEC[i].up1, VEC[i].lp0, VEC[i].lp1, VEC[i].en);
      #1;
      chk(TAG[i], lk_wait_o, VEC[i].exp);
    end
    @(negedge clk_i);
    drive(2'b00, '0, '0, '0, '0, 1'b1);

    // R6: last cycle before the decay edge, entries still set; update races the clear
    while (cyc != DECAY - 1) @(negedge clk_i);
    drive(2'b01, 32'h2C, '0, 32'h05, 32'h3F, 1'b1);
    #1;
    chk("R6", lk_wait_o, 2'b11);

    @(negedge clk_i);
    drive(2'b00, '0, '0, 32'h05, 32'h2C, 1'b1);
    #1;
    chk("R6", lk_wait_o, 2'b00);
    lk_pc_i[0] = 32'h3F;
    lk_pc_i[1] = 32'h07;
    #1;
    chk("R6", lk_wait_o, 2'b00);

    // R3: training resumes after the clear
    upd_vld_i   = 2'b01;
    upd_pc_i[0] = 32'h2C;
    @(negedge clk_i);
    drive(2'b00, '0, '0, 32'h2C, 32'h05, 1'b1);
    #1;
    chk("R3", lk_wait_o, 2'b01);

    // R1: asynchronous reset clears without a clock edge
    #1;
    rst_ni = 1'b0;
    #1;
    chk("R1", lk_wait_o, 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1", lk_wait_o, 2'b00);

    @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule